// File: doc/BRIEF.md
# MSI-X Vector Mask and Pending Controller

This block turns interrupt requests from an endpoint's internal logic into MSI-X message writes. It holds a table of vectors, each with a 64-bit message address, a 32-bit message data word and a mask bit, plus a pending-bit array and the function-level mask. A request names a vector. If the function and the vector are both unmasked, the block emits one memory-write request that carries that entry's address and data. If either mask is set, the block parks the request in the pending array and reports busy.

Software and the host reach the table and the pending array through a word-addressed register port. The table occupies four words per vector, starting at word 0x4000. The pending array starts at word 0x4200. A write into the table, or the function mask falling from 1 to 0, starts a sweep over every vector in ascending order. The sweep flushes each parked request whose vector is now unmasked. Mask checks and pending-bit updates happen in one clocked step, so a request and a sweep never race on the pending array.

The message output is valid/ready. Once `msg_valid` rises, `msg_addr` and `msg_data` hold steady until the cycle in which `msg_ready` is high. Only one message is outstanding at a time. While a message is waiting, the block accepts no request and the sweep does not advance, so back-pressure on the message port stalls both paths.

Top module: `msix_irq_ctrl`

## Requirements
- R1: After reset, `msg_valid` and `rsp_valid` are 0, `req_ready` is 1, every vector's mask bit reads 1, every message address and data word reads 0, and the pending array reads 0.
- R2: A request for vector index NUM_VEC or above is answered with status 2 (unsupported). It sets no pending bit and sends no message.
- R3: A request for an in-range vector, with the function mask clear, the vector's mask clear and a non-zero address, is answered with status 0. It also raises `msg_valid` with `msg_addr` = {high word, low word} and `msg_data` = the entry's data word.
- R4: A request for an in-range vector while the function mask or that vector's mask is set is answered with status 1 (busy). It sets that vector's pending bit and sends no message.
- R5: An unmasked request whose entry address is zero is answered with status 0. It sends no message and leaves the pending bit unchanged. No message ever carries a zero address.
- R6: Vector v occupies table words 0x4000+4v+k, where k=0 is the address low word, k=1 the address high word, k=2 the data word, and bit 0 of k=3 the mask. These words are written and read back through the register port.
- R7: Pending bit v reads at bit v%32 of word 0x4200+v/32. Writes to the pending words are ignored.
- R8: A table write while the function mask is clear starts a sweep over vectors 0 to NUM_VEC-1 in ascending order. Each vector that is pending and unmasked has its pending bit cleared, and it emits exactly one message if its address is non-zero.
- R9: A fall of `fn_mask` from 1 to 0 starts the same sweep. While `fn_mask` is 1, no sweep runs, a table write starts none, and no new message is produced.
- R10: A request is accepted in a cycle with `req_valid` and `req_ready` high, and `rsp_valid` pulses in the next cycle. `req_ready` is low in any cycle with a sweep trigger and throughout a sweep, so a sweep takes priority over a new request.
- R11: While `msg_valid` is high and `msg_ready` is low, address and data hold stable. `req_ready` stays low while `msg_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request present |
| req_vec | input | $clog2(NUM_VEC)+1 | Requested vector index |
| req_ready | output | 1 | Request can be taken this cycle |
| rsp_valid | output | 1 | Status of the last accepted request |
| rsp_status | output | 2 | 0 sent/ok, 1 busy (parked), 2 unsupported |
| fn_mask | input | 1 | Function-level mask from configuration space |
| reg_wr_en | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_waddr`, combinational |
| msg_valid | output | 1 | Memory-write request valid |
| msg_ready | input | 1 | Memory-write request accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the block with its defaults, NUM_VEC=16 and ADDR_W=15. The request index is then five bits wide, so the bench can drive the unsupported range 16..31 directly. A single pending word covers all vectors, which lets one read show every parked request at once. With sixteen vectors, the bench can park several requests under the function mask and observe the ascending flush order. It can also observe a zero-address vector that is cleared without a message, all while the message port is throttled by a repeating ready pattern.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_BUSY  = 2'd1,
    ST_UNSUP = 2'd2
  } rsp_e;

  // word addresses of the two register regions
  localparam int unsigned TBL_WBASE  = 32'h4000;
  localparam int unsigned PBA_WBASE  = 32'h4200;
  localparam int unsigned ENTRY_WRDS = 4;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [31:0]               wdata,
  input  logic [NUM_VEC-1:0]        pend,
  output logic [31:0]               rdata,
  output logic                      tbl_wr,
  output logic [NUM_VEC-1:0][63:0]  ent_addr,
  output logic [NUM_VEC-1:0][31:0]  ent_data,
  output logic [NUM_VEC-1:0]        ent_mask
);
  localparam int PBA_WORDS = (NUM_VEC + 31) / 32;
  localparam logic [ADDR_W-1:0] TBL_LO = ADDR_W'(TBL_WBASE);
  localparam logic [ADDR_W-1:0] TBL_HI = ADDR_W'(TBL_WBASE + NUM_VEC * ENTRY_WRDS);
  localparam logic [ADDR_W-1:0] PBA_LO = ADDR_W'(PBA_WBASE);
  localparam logic [ADDR_W-1:0] PBA_HI = ADDR_W'(PBA_WBASE + PBA_WORDS);

  logic                      tbl_hit, pba_hit;
  logic [ADDR_W-1:0]         tofs, pofs;
  logic [PBA_WORDS*32-1:0]   pend_pad;

  assign tbl_hit  = (waddr >= TBL_LO) && (waddr < TBL_HI);
  assign pba_hit  = (waddr >= PBA_LO) && (waddr < PBA_HI);
  assign tofs     = waddr - TBL_LO;
  assign pofs     = waddr - PBA_LO;
  assign tbl_wr   = wr_en && tbl_hit;
  assign pend_pad = (PBA_WORDS*32)'(pend);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    logic sel;
    assign sel = tbl_wr && (tofs[ADDR_W-1:2] == (ADDR_W-2)'(v));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_addr[v] <= '0;
        ent_data[v] <= '0;
        ent_mask[v] <= 1'b1;
      end else if (sel) begin
        case (tofs[1:0])
          2'd0:    ent_addr[v][31:0]  <= wdata;
          2'd1:    ent_addr[v][63:32] <= wdata;
          2'd2:    ent_data[v]        <= wdata;
          default: ent_mask[v]        <= wdata[0];
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (tbl_hit) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (tofs[ADDR_W-1:2] == (ADDR_W-2)'(v)) begin
          case (tofs[1:0])
            2'd0:    rdata = ent_addr[v][31:0];
            2'd1:    rdata = ent_addr[v][63:32];
            2'd2:    rdata = ent_data[v];
            default: rdata = {31'd0, ent_mask[v]};
          endcase
        end
      end
    end else if (pba_hit) begin
      for (int w = 0; w < PBA_WORDS; w++) begin
        if (pofs == ADDR_W'(w)) rdata = pend_pad[w*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/msix_pend_engine.sv
module msix_pend_engine
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  localparam int IDX_W  = $clog2(NUM_VEC),
  localparam int VEC_W  = IDX_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [VEC_W-1:0]          req_vec,
  output logic                      req_ready,
  output logic                      rsp_valid,
  output logic [1:0]                rsp_status,
  input  logic                      fn_mask,
  input  logic                      tbl_wr,
  input  logic [NUM_VEC-1:0][63:0]  ent_addr,
  input  logic [NUM_VEC-1:0][31:0]  ent_data,
  input  logic [NUM_VEC-1:0]        ent_mask,
  output logic [NUM_VEC-1:0]        pend,
  output logic                      msg_valid,
  input  logic                      msg_ready,
  output logic [63:0]               msg_addr,
  output logic [31:0]               msg_data
);
  logic             fn_q, trig, scan_busy, req_fire, in_range, scan_last;
  logic [IDX_W-1:0] scan_idx, req_idx;
  rsp_e             status_q;

  assign trig       = tbl_wr | (fn_q & ~fn_mask);
  assign req_ready  = !scan_busy && !msg_valid && !trig;
  assign req_fire   = req_valid && req_ready;
  assign req_idx    = req_vec[IDX_W-1:0];
  assign in_range   = req_vec < VEC_W'(NUM_VEC);
  assign scan_last  = scan_idx == IDX_W'(NUM_VEC - 1);
  assign rsp_status = status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fn_q      <= 1'b0;
      scan_busy <= 1'b0;
      scan_idx  <= '0;
      pend      <= '0;
      rsp_valid <= 1'b0;
      status_q  <= ST_OK;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      fn_q      <= fn_mask;
      rsp_valid <= 1'b0;
      if (msg_valid && msg_ready) msg_valid <= 1'b0;

      // request path: mask test and pending update in one step
      if (req_fire) begin
        rsp_valid <= 1'b1;
        if (!in_range) begin
          status_q <= ST_UNSUP;
        end else if (fn_mask || ent_mask[req_idx]) begin
          status_q      <= ST_BUSY;
          pend[req_idx] <= 1'b1;
        end else begin
          status_q <= ST_OK;
          if (ent_addr[req_idx] != '0) begin
            msg_valid <= 1'b1;
            msg_addr  <= ent_addr[req_idx];
            msg_data  <= ent_data[req_idx];
          end
        end
      end

      // sweep path: one vector per free cycle, restarted by any trigger
      if (trig) begin
        scan_busy <= !fn_mask;
        scan_idx  <= '0;
      end else if (scan_busy) begin
        if (fn_mask) begin
          scan_busy <= 1'b0;
        end else if (!msg_valid) begin
          if (pend[scan_idx] && !ent_mask[scan_idx]) begin
            pend[scan_idx] <= 1'b0;
            if (ent_addr[scan_idx] != '0) begin
              msg_valid <= 1'b1;
              msg_addr  <= ent_addr[scan_idx];
              msg_data  <= ent_data[scan_idx];
            end
          end
          scan_idx <= scan_idx + 1'b1;
          if (scan_last) scan_busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/msix_irq_ctrl.sv
module msix_irq_ctrl #(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 15,
  localparam int VEC_W  = $clog2(NUM_VEC) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vec,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  input  logic              fn_mask,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  logic [NUM_VEC-1:0][63:0] ent_addr;
  logic [NUM_VEC-1:0][31:0] ent_data;
  logic [NUM_VEC-1:0]       ent_mask;
  logic [NUM_VEC-1:0]       pend;
  logic                     tbl_wr;

  msix_vec_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .waddr    (reg_waddr),
    .wdata    (reg_wdata),
    .pend     (pend),
    .rdata    (reg_rdata),
    .tbl_wr   (tbl_wr),
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .ent_mask (ent_mask)
  );

  msix_pend_engine #(.NUM_VEC(NUM_VEC)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vec    (req_vec),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .fn_mask    (fn_mask),
    .tbl_wr     (tbl_wr),
    .ent_addr   (ent_addr),
    .ent_data   (ent_data),
    .ent_mask   (ent_mask),
    .pend       (pend),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data)
  );
endmodule

// File: rtl/msix_irq_ctrl_chk.sv
module msix_irq_ctrl_chk
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 15,
  localparam int VEC_W  = $clog2(NUM_VEC) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [VEC_W-1:0]  req_vec,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic              fn_mask,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_waddr,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [63:0]       msg_addr,
  input logic [31:0]       msg_data
);
  logic fire, tbl_write;
  assign fire      = req_valid && req_ready;
  assign tbl_write = reg_wr_en && (reg_waddr >= ADDR_W'(TBL_WBASE))
                     && (reg_waddr < ADDR_W'(TBL_WBASE + NUM_VEC * ENTRY_WRDS));

  p_unsup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (req_vec >= VEC_W'(NUM_VEC)) |=> rsp_valid && rsp_status == 2'd2 && !msg_valid);

  p_fn_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && fn_mask && (req_vec < VEC_W'(NUM_VEC)) |=> rsp_status == 2'd1 && !msg_valid);

  p_no_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr != 64'd0);

  p_fn_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fn_mask) && !$past(msg_valid) |-> !msg_valid);

  p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  p_rsp_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);

  p_write_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_write |-> !req_ready);

  p_msg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);
endmodule

bind msix_irq_ctrl msix_irq_ctrl_chk #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_vec    (req_vec),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .fn_mask    (fn_mask),
  .reg_wr_en  (reg_wr_en),
  .reg_waddr  (reg_waddr),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data)
);

// File: tb/msix_irq_ctrl_bench.sv
module msix_irq_ctrl_bench;
  localparam int NV = 16;
  localparam int AW = 15;
  localparam int TB = 'h4000;
  localparam int PB = 'h4200;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0;
  logic [4:0]    req_vec = '0;
  logic          req_ready, rsp_valid;
  logic [1:0]    rsp_status;
  logic          fn_mask = 0;
  logic          reg_wr_en = 0;
  logic [AW-1:0] reg_waddr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          msg_valid;
  logic          msg_ready = 0;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  always #2.5 clk = ~clk;

  msix_irq_ctrl #(.NUM_VEC(NV), .ADDR_W(AW)) u_msix_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .fn_mask(fn_mask), .reg_wr_en(reg_wr_en), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [95:0] exp_q[$];

  // bench-side model of the table
  logic [31:0] m_lo[NV], m_hi[NV], m_dat[NV];
  logic        m_mask[NV], m_pend[NV];
  logic        m_fn = 0;

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: throttles ready and compares each accepted message
  always @(negedge clk) begin
    cyc++;
    msg_ready = (cyc % 3) != 1;
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) chk(0, "R3/R8 unexpected message", {msg_addr, msg_data}, '0);
      else begin
        logic [95:0] e;
        e = exp_q.pop_front();
        chk({msg_addr, msg_data} == e, "R3/R8 message", {msg_addr, msg_data}, e);
      end
    end
  end

  function automatic void model_scan();
    for (int v = 0; v < NV; v++)
      if (m_pend[v] && !m_mask[v]) begin
        m_pend[v] = 0;
        if ({m_hi[v], m_lo[v]} != 64'd0) exp_q.push_back({m_hi[v], m_lo[v], m_dat[v]});
      end
  endfunction

  function automatic logic [31:0] model_pba();
    logic [31:0] p = '0;
    for (int v = 0; v < NV; v++) p[v] = m_pend[v];
    return p;
  endfunction

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while ((exp_q.size() != 0 || msg_valid || !req_ready) && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, "R8 drained", 96'(exp_q.size()), 0);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    if (a >= TB && a < TB + 4 * NV) begin
      int v = (a - TB) / 4;
      case ((a - TB) % 4)
        0: m_lo[v] = d;
        1: m_hi[v] = d;
        2: m_dat[v] = d;
        default: m_mask[v] = d[0];
      endcase
      if (!m_fn) model_scan();
    end
    @(negedge clk);
    reg_wr_en = 1; reg_waddr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
    wait_idle();
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_waddr = AW'(a);
    #1 chk(reg_rdata == e, tag, 96'(reg_rdata), 96'(e));
  endtask

  task automatic set_fn(input logic f);
    if (m_fn && !f) begin m_fn = 0; model_scan(); end
    m_fn = f;
    @(negedge clk);
    fn_mask = f;
    wait_idle();
  endtask

  task automatic do_req(input int v, input string tag);
    logic [1:0] es;
    bit sends = 0;
    int n = 0;
    if (v >= NV) es = 2;
    else if (m_fn || m_mask[v]) begin es = 1; m_pend[v] = 1; end
    else begin
      es = 0;
      if ({m_hi[v], m_lo[v]} != 64'd0) begin
        exp_q.push_back({m_hi[v], m_lo[v], m_dat[v]});
        sends = 1;
      end
    end
    @(negedge clk);
    req_valid = 1; req_vec = 5'(v);
    while (!req_ready && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_status == es, {tag, " status, R10 timing"}, {rsp_valid, rsp_status}, {1'b1, es});
    chk(msg_valid == sends, {tag, " message raised"}, 96'(msg_valid), 96'(sends));
    if (sends) chk(!req_ready, "R11 ready low with message out", 96'(req_ready), 0);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog (all)", 0, 1);
    report();
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      m_lo[v] = 0; m_hi[v] = 0; m_dat[v] = 0; m_mask[v] = 1; m_pend[v] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!msg_valid && !rsp_valid && req_ready, "R1 reset outputs",
        {msg_valid, rsp_valid, req_ready}, 3'b001);
    rd(TB + 3, 1, "R1 mask vec0");
    rd(TB + 4 * 15 + 3, 1, "R1 mask vec15");
    rd(TB + 4 * 15, 0, "R1 addr vec15");
    rd(PB, 0, "R1 pending");

    do_req(3, "R4 masked vector");
    rd(PB, 32'h8, "R4 pending bit 3");
    do_req(20, "R2 out of range");
    do_req(16, "R2 index 16");
    rd(PB, 32'h8, "R2 no side effect");

    wr(TB + 20, 32'h3456_7800);
    wr(TB + 21, 32'h0000_0012);
    wr(TB + 22, 32'h0000_5005);
    wr(TB + 23, 0);
    rd(TB + 20, 32'h3456_7800, "R6 addr lo");
    rd(TB + 21, 32'h0000_0012, "R6 addr hi");
    rd(TB + 22, 32'h0000_5005, "R6 data");
    rd(TB + 23, 0, "R6 mask");
    do_req(5, "R3 unmasked send");
    do_req(5, "R3 second send");

    wr(PB, 32'hFFFF);
    rd(PB, 32'h8, "R7 pending write ignored");

    wr(TB + 12, 32'h0000_1000);
    wr(TB + 13, 32'hFEE0_0000);
    wr(TB + 14, 32'h33);
    wr(TB + 15, 0);
    rd(PB, 0, "R8 unmask flushes vec3");

    set_fn(1);
    do_req(5, "R4 function mask");
    wr(TB + 28, 32'h7700);
    wr(TB + 30, 32'h77);
    wr(TB + 31, 0);
    do_req(7, "R4 function mask vec7");
    repeat (20) @(negedge clk);
    chk(!msg_valid, "R9 quiet while masked", 96'(msg_valid), 0);
    rd(PB, 32'h00A0, "R9 both parked");
    set_fn(0);
    rd(PB, 0, "R9 unmask flushes 5 then 7");

    wr(TB + 43, 0);
    do_req(10, "R5 zero address");
    rd(PB, 0, "R5 no pending");
    set_fn(1);
    do_req(10, "R4 zero address masked");
    rd(PB, 32'h0400, "R4 pending 10");
    set_fn(0);
    rd(PB, model_pba(), "R8 zero address cleared silently");

    // sweep trigger and request in the same cycle
    exp_q.push_back({m_hi[5], m_lo[5], m_dat[5]});
    m_dat[12] = 32'h1212;
    @(negedge clk);
    reg_wr_en = 1; reg_waddr = AW'(TB + 50); reg_wdata = 32'h1212;
    req_valid = 1; req_vec = 5'd5;
    #1 chk(!req_ready, "R10 trigger blocks request", 96'(req_ready), 0);
    @(negedge clk);
    reg_wr_en = 0;
    #1 chk(!req_ready, "R10 sweep blocks request", 96'(req_ready), 0);
    begin
      int n = 0;
      while (!req_ready && n < 500) begin @(negedge clk); n++; end
    end
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid && rsp_status == 0, "R10 request after sweep", {rsp_valid, rsp_status}, 3'b100);
    wait_idle();

    report();
    $finish;
  end
endmodule